// File: doc/BRIEF.md
# Queue Controller Register and Doorbell Decoder

This block is the memory-mapped front end of a queue-based storage controller. A host-side port carries 32-bit writes and reads. Below offset 0x1000 it reaches a small register file: a version word, a capability word, an interrupt mask with separate set and clear addresses, a configuration word, a status word, the admin queue size word and two 64-bit admin queue base addresses. From offset 0x1000 upward the write port becomes a doorbell window. Each accepted doorbell write produces a one-cycle strobe that carries the queue id, the queue kind and the new index value.

When the configuration enable bit rises, the block checks the admin queue setup against the capability limits. It then reports ready or fatal and, on success, emits a one-cycle start pulse. A falling enable emits a one-cycle reset pulse for the queue logic. The queue logic lies outside this block: it reports which queues exist and how deep each one is. The register port and the doorbell strobe are plain one-cycle signals with no back-pressure. A doorbell strobe must be taken in the cycle it is shown, and read data returns exactly one cycle after the read request.

Top module: `qctl_regs`

## Requirements
- R1: A write to offset 0x010 ORs the data into the 32-bit interrupt mask. A write to 0x014 clears the set bits of the data from the mask. Reading either offset returns the mask. The mask resets to 0.
- R2: The configuration word is at 0x018, with bit 0 enable, bits 4:1 page code (page = 4096 << code) and bits 6:5 shutdown request. A 0-to-1 enable write that passes validation sets ready (status bit 0), clears fatal (status bit 1) and raises start_pulse for one cycle. Writing enable=1 while it is already 1 raises no pulse.
- R3: A 0-to-1 enable write fails validation, and so sets fatal and leaves ready at 0 with no start pulse, in any of these cases: admin_live is high; the page code is outside PG_MIN..PG_MAX; either admin queue base is zero or not page aligned; either size field of 0x020 (bits 15:0 submission, bits 31:16 completion) is 0 or above 4095.
- R4: A 1-to-0 enable write raises reset_pulse for one cycle and clears ready.
- R5: A configuration write whose shutdown field goes from zero to nonzero sets shutdown-done (status bit 2). One that returns the field to zero clears it. Status at 0x01C ignores writes.
- R6: An aligned doorbell write at address A ≥ 0x1000 has index (A−0x1000)/4 and queue id (A−0x1000)>>3. An even index is a submission-tail doorbell (db_is_cq=0); an odd index is a completion-head doorbell (db_is_cq=1). The strobe db_valid appears one cycle after the write with the low 16 write bits in db_value.
- R7: A doorbell write is dropped with no strobe when A is not a multiple of 4, when the queue id is ≥ NQ or its live bit is low, or when the low 16 data bits are not below that queue's depth. Data bits 31:16 are ignored.
- R8: Offset 0x000 reads 0x00010001. Offset 0x008 reads 0x0F0107FF (max entries 0x7FF in bits 15:0, contiguous-required bit 16, timeout 0xF in bits 31:24). Offset 0x00C reads PG_MAX in bits 7:4 and PG_MIN in bits 3:0.
- R9: The submission base is written and read as 32-bit halves at 0x028 (low) and 0x02C (high); the completion base at 0x030 and 0x034. The size word at 0x020 reads back as written.
- R10: rd_valid rises one cycle after a read request with its data. Unmapped offsets below 0x1000 and all doorbell addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| admin_live | input | 1 | Admin queues already exist |
| sq_live | input | NQ | Submission queue exists, one bit per id |
| cq_live | input | NQ | Completion queue exists, one bit per id |
| sq_depth | input | NQ*16 | Submission queue depths, 16 bits per id |
| cq_depth | input | NQ*16 | Completion queue depths, 16 bits per id |
| start_pulse | output | 1 | Controller start, one cycle |
| reset_pulse | output | 1 | Controller reset, one cycle |
| ready | output | 1 | Ready status |
| fatal | output | 1 | Fatal status |
| shdn_done | output | 1 | Shutdown-complete status |
| db_valid | output | 1 | Doorbell strobe |
| db_is_cq | output | 1 | 1 for a completion-head doorbell |
| db_qid | output | $clog2(NQ) | Doorbell queue id |
| db_value | output | 16 | Doorbell index value |

## Verification
The bench uses the defaults NQ=4, PG_MIN=0 and PG_MAX=4. Its random doorbell addresses cover 0x1000 to 0x103F, which includes ids 4 to 7 past the implemented queues as well as every misalignment. Depths between 1 and 32, with values mostly drawn under 40, place many writes on both sides of the depth bound. A page range of 4 KiB to 64 KiB lets alignment failures and out-of-range page codes (5 and above) be reached with small base addresses.

// File: rtl/qctl_pkg.sv
package qctl_pkg;
  localparam logic [11:0] OFF_VER  = 12'h000;
  localparam logic [11:0] OFF_CAPL = 12'h008;
  localparam logic [11:0] OFF_CAPH = 12'h00C;
  localparam logic [11:0] OFF_MSET = 12'h010;
  localparam logic [11:0] OFF_MCLR = 12'h014;
  localparam logic [11:0] OFF_CFG  = 12'h018;
  localparam logic [11:0] OFF_STAT = 12'h01C;
  localparam logic [11:0] OFF_ATTR = 12'h020;
  localparam logic [11:0] OFF_SQBL = 12'h028;
  localparam logic [11:0] OFF_SQBH = 12'h02C;
  localparam logic [11:0] OFF_CQBL = 12'h030;
  localparam logic [11:0] OFF_CQBH = 12'h034;

  localparam int          DB_BASE   = 32'h1000;
  localparam logic [31:0] VER_WORD  = 32'h0001_0001;
  localparam logic [31:0] CAP_LOW   = {8'h0F, 7'd0, 1'b1, 16'h07FF};
  localparam int          QSIZE_MAX = 4095;

  typedef struct packed {
    logic [1:0] shn;
    logic [3:0] pg;
    logic       en;
  } cfg_t;

  typedef struct packed {
    logic shdone;
    logic fatal;
    logic ready;
  } stat_t;
endpackage

// File: rtl/qctl_cfg_check.sv
module qctl_cfg_check #(
  parameter int PG_MIN = 0,
  parameter int PG_MAX = 4
) (
  input  logic [3:0]  pg,
  input  logic [63:0] sq_base,
  input  logic [63:0] cq_base,
  input  logic [31:0] attr,
  input  logic        admin_live,
  output logic        cfg_ok
);
  import qctl_pkg::*;

  logic [63:0] pg_mask;
  logic        lo_ok, hi_ok, base_ok, size_ok;

  generate
    if (PG_MIN == 0) begin : g_lo_free
      assign lo_ok = 1'b1;
    end else begin : g_lo_chk
      assign lo_ok = pg >= 4'(PG_MIN);
    end
    if (PG_MAX >= 15) begin : g_hi_free
      assign hi_ok = 1'b1;
    end else begin : g_hi_chk
      assign hi_ok = pg <= 4'(PG_MAX);
    end
  endgenerate

  always_comb begin
    pg_mask = (64'h1000 << pg) - 64'd1;
    base_ok = (sq_base != '0) && (cq_base != '0) &&
              ((sq_base & pg_mask) == '0) && ((cq_base & pg_mask) == '0);
    size_ok = (attr[15:0] != '0) && (attr[15:0] <= 16'(QSIZE_MAX)) &&
              (attr[31:16] != '0) && (attr[31:16] <= 16'(QSIZE_MAX));
    cfg_ok  = !admin_live && lo_ok && hi_ok && base_ok && size_ok;
  end
endmodule

// File: rtl/qctl_db_decode.sv
module qctl_db_decode #(
  parameter int ADDR_W = 16,
  parameter int NQ     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [15:0]           wval,
  input  logic [NQ-1:0]         sq_live,
  input  logic [NQ-1:0]         cq_live,
  input  logic [NQ*16-1:0]      sq_depth,
  input  logic [NQ*16-1:0]      cq_depth,
  output logic                  db_valid,
  output logic                  db_is_cq,
  output logic [$clog2(NQ)-1:0] db_qid,
  output logic [15:0]           db_value
);
  import qctl_pkg::*;
  localparam int QW = $clog2(NQ);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-4:0] qid_full;
  logic [QW-1:0]     qid;
  logic              is_cq, live, accept;
  logic [15:0]       depth;

  always_comb begin
    off      = addr - BASE_A;
    qid_full = off[ADDR_W-1:3];
    qid      = qid_full[QW-1:0];
    is_cq    = off[2];
    live     = is_cq ? cq_live[qid] : sq_live[qid];
    depth    = is_cq ? cq_depth[int'(qid)*16 +: 16] : sq_depth[int'(qid)*16 +: 16];
    accept   = wr && (addr >= BASE_A) && (off[1:0] == 2'b00) &&
               (qid_full < (ADDR_W-3)'(NQ)) && live && (wval < depth);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_valid <= 1'b0;
      db_is_cq <= 1'b0;
      db_qid   <= '0;
      db_value <= '0;
    end else begin
      db_valid <= accept;
      if (accept) begin
        db_is_cq <= is_cq;
        db_qid   <= qid;
        db_value <= wval;
      end
    end
  end
endmodule

// File: rtl/qctl_regs.sv
module qctl_regs
  import qctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NQ     = 4,
  parameter int PG_MIN = 0,
  parameter int PG_MAX = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  input  logic                  admin_live,
  input  logic [NQ-1:0]         sq_live,
  input  logic [NQ-1:0]         cq_live,
  input  logic [NQ*16-1:0]      sq_depth,
  input  logic [NQ*16-1:0]      cq_depth,
  output logic                  start_pulse,
  output logic                  reset_pulse,
  output logic                  ready,
  output logic                  fatal,
  output logic                  shdn_done,
  output logic                  db_valid,
  output logic                  db_is_cq,
  output logic [$clog2(NQ)-1:0] db_qid,
  output logic [15:0]           db_value
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);
  localparam logic [31:0] CAP_HIGH = {24'd0, 4'(PG_MAX), 4'(PG_MIN)};

  logic [31:0] int_mask, attr_q, rd_word;
  logic [63:0] sqb_q, cqb_q;
  cfg_t        cfg_q, cfg_new;
  stat_t       stat_q, stat_nxt;
  logic        in_regs, cfg_ok, en_rise, en_fall;
  logic [11:0] roff;

  assign in_regs = bus_addr < BASE_A;
  assign roff    = bus_addr[11:0];
  assign cfg_new = cfg_t'(bus_wdata[6:0]);
  assign en_rise = cfg_new.en && !cfg_q.en;
  assign en_fall = !cfg_new.en && cfg_q.en;

  qctl_cfg_check #(.PG_MIN(PG_MIN), .PG_MAX(PG_MAX)) u_check (
    .pg(cfg_new.pg), .sq_base(sqb_q), .cq_base(cqb_q), .attr(attr_q),
    .admin_live(admin_live), .cfg_ok(cfg_ok)
  );

  qctl_db_decode #(.ADDR_W(ADDR_W), .NQ(NQ)) u_db (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wval(bus_wdata[15:0]),
    .sq_live(sq_live), .cq_live(cq_live), .sq_depth(sq_depth), .cq_depth(cq_depth),
    .db_valid(db_valid), .db_is_cq(db_is_cq), .db_qid(db_qid), .db_value(db_value)
  );

  always_comb begin
    stat_nxt = stat_q;
    if (en_rise) begin
      stat_nxt.ready = cfg_ok;
      stat_nxt.fatal = !cfg_ok;
    end else if (en_fall) begin
      stat_nxt.ready = 1'b0;
    end
    if (cfg_new.shn != '0 && cfg_q.shn == '0)      stat_nxt.shdone = 1'b1;
    else if (cfg_new.shn == '0 && cfg_q.shn != '0) stat_nxt.shdone = 1'b0;
  end

  always_comb begin
    rd_word = '0;
    if (in_regs) begin
      case (roff)
        OFF_VER:  rd_word = VER_WORD;
        OFF_CAPL: rd_word = CAP_LOW;
        OFF_CAPH: rd_word = CAP_HIGH;
        OFF_MSET, OFF_MCLR: rd_word = int_mask;
        OFF_CFG:  rd_word = {25'd0, cfg_q};
        OFF_STAT: rd_word = {29'd0, stat_q};
        OFF_ATTR: rd_word = attr_q;
        OFF_SQBL: rd_word = sqb_q[31:0];
        OFF_SQBH: rd_word = sqb_q[63:32];
        OFF_CQBL: rd_word = cqb_q[31:0];
        OFF_CQBH: rd_word = cqb_q[63:32];
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_mask    <= '0;
      cfg_q       <= '0;
      stat_q      <= '0;
      attr_q      <= '0;
      sqb_q       <= '0;
      cqb_q       <= '0;
      start_pulse <= 1'b0;
      reset_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      reset_pulse <= 1'b0;
      if (bus_wr && in_regs) begin
        case (roff)
          OFF_MSET: int_mask <= int_mask | bus_wdata;
          OFF_MCLR: int_mask <= int_mask & ~bus_wdata;
          OFF_CFG: begin
            cfg_q       <= cfg_new;
            stat_q      <= stat_nxt;
            start_pulse <= en_rise && cfg_ok;
            reset_pulse <= en_fall;
          end
          OFF_ATTR: attr_q         <= bus_wdata;
          OFF_SQBL: sqb_q[31:0]    <= bus_wdata;
          OFF_SQBH: sqb_q[63:32]   <= bus_wdata;
          OFF_CQBL: cqb_q[31:0]    <= bus_wdata;
          OFF_CQBH: cqb_q[63:32]   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_word;
    end
  end

  assign ready     = stat_q.ready;
  assign fatal     = stat_q.fatal;
  assign shdn_done = stat_q.shdone;
endmodule

// File: rtl/qctl_regs_chk.sv
module qctl_regs_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       int_mask,
  input logic              rd_valid,
  input logic              start_pulse,
  input logic              reset_pulse,
  input logic              ready,
  input logic              fatal,
  input logic              db_valid
);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(12'h014);

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET) |=> ((int_mask & $past(bus_wdata)) == $past(bus_wdata))); // R1
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCLR) |=> ((int_mask & $past(bus_wdata)) == '0)); // R1
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (ready && !fatal)); // R2
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && fatal)); // R3
  AST_RESET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> (!ready && !start_pulse)); // R4
  AST_DB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> $past(bus_wr)); // R6
  AST_DB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> ($past(bus_addr[1:0]) == 2'b00)); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid); // R10
endmodule

bind qctl_regs qctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .int_mask(int_mask), .rd_valid(rd_valid),
  .start_pulse(start_pulse), .reset_pulse(reset_pulse), .ready(ready),
  .fatal(fatal), .db_valid(db_valid)
);

// File: tb/qctl_regs_tb.sv
`timescale 1ns/1ps
module qctl_regs_tb;
  localparam int NQ = 4;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic admin_live = 1'b0;
  logic [NQ-1:0] sq_live = '0, cq_live = '0;
  logic [NQ*16-1:0] sq_depth = '0, cq_depth = '0;
  logic start_pulse, reset_pulse, ready, fatal, shdn_done;
  logic db_valid, db_is_cq;
  logic [1:0] db_qid;
  logic [15:0] db_value;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  qctl_regs #(.ADDR_W(AW), .NQ(NQ), .PG_MIN(0), .PG_MAX(4)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  function automatic logic [31:0] cfg_word(input int shn, input int pg, input bit en);
    return (32'(shn) << 5) | (32'(pg) << 1) | 32'(en);
  endfunction

  // expected doorbell: {accept, is_cq, qid, value}
  function automatic logic [19:0] exp_db(input logic [AW-1:0] a, input logic [31:0] d);
    int off, q;
    logic cq;
    logic [15:0] dep;
    if (a < 16'h1000) return '0;
    off = int'(a) - 32'h1000;
    if (off % 4 != 0) return '0;
    cq = ((off / 4) % 2) == 1;
    q  = off / 8;
    if (q >= NQ) return '0;
    if (cq ? !cq_live[q] : !sq_live[q]) return '0;
    dep = cq ? cq_depth[q*16 +: 16] : sq_depth[q*16 +: 16];
    if (d[15:0] >= dep) return '0;
    return {1'b1, cq, 2'(q), d[15:0]};
  endfunction

  task automatic setup(input logic [31:0] attr, input logic [63:0] sb, input logic [63:0] cb);
    wr(16'h020, attr);
    wr(16'h028, sb[31:0]); wr(16'h02C, sb[63:32]);
    wr(16'h030, cb[31:0]); wr(16'h034, cb[63:32]);
  endtask

  // enable from disabled; expect pass or fail
  task automatic try_enable(input string tag, input int pg, input bit pass);
    wr(16'h018, cfg_word(0, pg, 1'b1));
    chk({tag, " start"}, {31'd0, start_pulse}, {31'd0, pass});
    chk({tag, " ready"}, {31'd0, ready}, {31'd0, pass});
    chk({tag, " fatal"}, {31'd0, fatal}, {31'd0, !pass});
    wr(16'h018, cfg_word(0, pg, 1'b0));
    chk({tag, " R4 reset_pulse"}, {31'd0, reset_pulse}, 32'd1);
    chk({tag, " R4 ready"}, {31'd0, ready}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, model;
    logic [19:0] e;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R2 reset ready", {31'd0, ready}, 32'd0);
    chk("R3 reset fatal", {31'd0, fatal}, 32'd0);
    rd(16'h01C, r); chk("R5 reset status", r, 32'd0);
    rd(16'h010, r); chk("R1 reset mask", r, 32'd0);

    // R8 identity words
    rd(16'h000, r); chk("R8 version", r, 32'h0001_0001);
    rd(16'h008, r); chk("R8 cap low", r, 32'h0F01_07FF);
    rd(16'h00C, r); chk("R8 cap high", r, 32'h0000_0040);

    // R9 base halves
    setup(32'h0FFF_0001, 64'h1234_5678_0000_2000, 64'h0000_0001_0000_3000);
    rd(16'h028, r); chk("R9 sq base low", r, 32'h0000_2000);
    rd(16'h02C, r); chk("R9 sq base high", r, 32'h1234_5678);
    rd(16'h030, r); chk("R9 cq base low", r, 32'h0000_3000);
    rd(16'h034, r); chk("R9 cq base high", r, 32'h0000_0001);
    rd(16'h020, r); chk("R9 attr", r, 32'h0FFF_0001);

    // R10 unmapped reads
    rd(16'h040, r); chk("R10 gap", r, 32'd0);
    rd(16'h0FFC, r); chk("R10 top gap", r, 32'd0);
    rd(16'h1000, r); chk("R10 doorbell read", r, 32'd0);

    // R1 random mask ops
    model = '0;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 2) begin wr(16'h010, d); model |= d; end
      else begin wr(16'h014, d); model &= ~d; end
      rd(($urandom % 2) ? 16'h010 : 16'h014, r);
      chk("R1 mask", r, model);
    end

    // R2/R3/R4 enable validation
    setup({16'd63, 16'd31}, 64'h2000, 64'h3000);
    try_enable("R2 good pg0", 0, 1'b1);
    try_enable("R3 misaligned pg1", 1, 1'b0);
    rd(16'h01C, r); chk("R3 status fatal stays", r, 32'h2);
    setup({16'd63, 16'd31}, 64'h4000, 64'h6000);
    try_enable("R2 good pg1 clears fatal", 1, 1'b1);
    setup({16'd63, 16'd31}, 64'h10_0000, 64'h20_0000);
    try_enable("R2 good pg4 boundary", 4, 1'b1);
    try_enable("R3 pg5 over max", 5, 1'b0);
    setup({16'd4095, 16'd4095}, 64'h4000, 64'h6000);
    try_enable("R2 size 4095", 0, 1'b1);
    setup({16'd4096, 16'd31}, 64'h4000, 64'h6000);
    try_enable("R3 cq size 4096", 0, 1'b0);
    setup({16'd63, 16'd0}, 64'h4000, 64'h6000);
    try_enable("R3 sq size 0", 0, 1'b0);
    setup({16'd63, 16'd31}, 64'h0, 64'h6000);
    try_enable("R3 zero base", 0, 1'b0);
    setup({16'd63, 16'd31}, 64'h4000, 64'h6000);
    admin_live = 1'b1;
    try_enable("R3 admin live", 0, 1'b0);
    admin_live = 1'b0;

    // R2 no pulse on re-write of enable
    wr(16'h018, cfg_word(0, 0, 1'b1));
    chk("R2 start on rise", {31'd0, start_pulse}, 32'd1);
    wr(16'h018, cfg_word(0, 0, 1'b1));
    chk("R2 no start when held", {31'd0, start_pulse}, 32'd0);
    chk("R2 ready held", {31'd0, ready}, 32'd1);

    // R5 shutdown
    wr(16'h018, cfg_word(1, 0, 1'b1));
    chk("R5 shutdown set", {31'd0, shdn_done}, 32'd1);
    wr(16'h018, cfg_word(2, 0, 1'b1));
    chk("R5 shutdown held", {31'd0, shdn_done}, 32'd1);
    wr(16'h01C, 32'h0);
    rd(16'h01C, r); chk("R5 status write ignored", r, 32'h5);
    wr(16'h018, cfg_word(0, 0, 1'b1));
    chk("R5 shutdown cleared", {31'd0, shdn_done}, 32'd0);

    // R6/R7 directed doorbells
    sq_live = 4'b1111; cq_live = 4'b1111;
    sq_depth = {4{16'd8}}; cq_depth = {4{16'd8}};
    wr(16'h1000 + 16'h18, 32'hABCD_0007);
    chk("R6 sq3 tail valid", {31'd0, db_valid}, 32'd1);
    chk("R6 sq3 fields", {13'd0, db_is_cq, db_qid, db_value}, {13'd0, 1'b0, 2'd3, 16'd7});
    wr(16'h1004, 32'h0000_0008);
    chk("R7 value equals depth dropped", {31'd0, db_valid}, 32'd0);
    wr(16'h1006, 32'h0000_0001);
    chk("R7 misaligned dropped", {31'd0, db_valid}, 32'd0);
    wr(16'h1000 + 16'h20, 32'h0000_0001);
    chk("R7 qid beyond NQ dropped", {31'd0, db_valid}, 32'd0);

    // R6/R7 random doorbells
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      sq_live = 4'($urandom); cq_live = 4'($urandom);
      for (int q = 0; q < NQ; q++) begin
        sq_depth[q*16 +: 16] = 16'(1 + $urandom % 32);
        cq_depth[q*16 +: 16] = 16'(1 + $urandom % 32);
      end
      a = 16'h1000 + 16'($urandom % 64);
      d = {16'($urandom), 16'($urandom % 40)};
      e = exp_db(a, d);
      wr(a, d);
      chk("R7 random doorbell accept", {31'd0, db_valid}, {31'd0, e[19]});
      if (e[19])
        chk("R6 random doorbell fields", {13'd0, db_is_cq, db_qid, db_value}, {13'd0, e[18:0]});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule